// File: doc/BRIEF.md
# Single-cycle 32-bit RISC subset core

This block is a processor that completes one instruction every clock cycle. Each instruction is a fixed 32-bit word. It fetches the word from an internal instruction array, decodes it, reads up to two of its 32 general registers and computes a result. It can then access an internal data array, write one register back and pick the next program counter, all within the same cycle. The instruction set is a small subset of three-operand register arithmetic, immediate arithmetic and logic, word loads and stores, equality branches and an absolute jump.

The instruction array is filled through a plain write port, normally while reset is held, so no file is involved. Two read-only observation ports show any register and any data word, so a program's final state can be inspected from outside. A program usually ends in a jump to itself, which leaves the state stable for inspection.

Every instruction uses the same fixed field positions. The opcode is in bits 31:26, the first source register in 25:21 and the second source or load/immediate target in 20:16. The register-form destination is in 15:11, the shift amount in 10:6 and the function code in 5:0. The 16-bit immediate is in 15:0 and the 26-bit jump target in 25:0. How the immediate is extended depends on the instruction, so a constant of any width can be built with an upper-immediate load followed by an OR-immediate.

Top module: `sc_risc32_core`

## Requirements
- R1: Reset is synchronous and active high. The cycle after a clock edge with reset asserted, the program counter reads 0 and all 32 registers read 0. No register or data word changes while reset is held.
- R2: Register 0 always reads 0. Any instruction that names it as destination leaves it at 0.
- R3: Opcode 0 selects the register form, which writes register rd (bits 15:11). The function codes are add 32, sub 34, and 36, or 37 and slt 42. slt compares as signed and writes 1 or 0. The word 0x00AF8020 adds registers 5 and 15 into register 16.
- R4: Function code 0 shifts rt left and function code 6 shifts rt right, by the amount in bits 10:6. Both fill the vacated bits with zeros, and the result is written to rd.
- R5: addi (opcode 8) and slti (opcode 10) sign-extend the 16-bit immediate. slti compares as signed. Both write rt.
- R6: andi (opcode 12) and ori (opcode 13) zero-extend the immediate. lui (opcode 15) writes the immediate into bits 31:16 of rt and clears bits 15:0. All three write rt.
- R7: lw (opcode 35) and sw (opcode 43) address the byte address rs plus the sign-extended offset, and use bits above 1 as the word index. lw writes the word to rt, and sw stores rt on the clock edge.
- R8: beq (opcode 4) branches when rs equals rt, and bne (opcode 5) branches when they differ. A taken branch goes to PC+4 plus the sign-extended offset times 4. Otherwise the next PC is PC+4.
- R9: j (opcode 2) sets the next PC to bits 31:28 of PC+4, then the 26-bit target, then two zero bits.
- R10: Any other instruction advances the PC by 4, and the PC stays a multiple of 4. An unrecognised opcode or register-form function code changes no register and no data word.
- R11: A write on the load port stores the word at the given instruction index. Fetch reads the index given by PC bits above 1.
- R12: The observation ports show, without delay, the selected register and the selected data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction array write strobe |
| imem_waddr | input | clog2(IMEM_WORDS) | Instruction word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_reg_sel | input | 5 | Register to observe |
| dbg_reg_data | output | 32 | Contents of the observed register |
| dbg_mem_idx | input | clog2(DMEM_WORDS) | Data word index to observe |
| dbg_mem_data | output | 32 | Contents of the observed data word |
| fetch_pc | output | 32 | Current program counter |

## Verification
The bench goes after immediate extension. A core that sign-extends andi/ori would turn 0xFFFF into all ones, and one that zero-extends addi/slti would treat -1 as 65535 and get the signed compare wrong. It shifts a word with bit 31 set to the right by 31 to catch an arithmetic fill, and uses negative operands in slt to catch an unsigned compare. It runs a loop with a backward branch, plus both arms of an if-then-else, so a wrong offset scale or sign, or a swapped beq/bne, lands on the wrong instructions and leaves different registers. It also writes register 0, uses negative load/store offsets and feeds undefined opcodes and function codes. A core that wrote anyway, dropped the offset sign or let an illegal store through would leave register or memory contents that differ from the bench's instruction-level model.

// File: rtl/sc_risc32_pkg.sv
package sc_risc32_pkg;

   // opcode field values (bits 31:26)
   localparam logic [5:0] OP_REG  = 6'd0;
   localparam logic [5:0] OP_JMP  = 6'd2;
   localparam logic [5:0] OP_BEQ  = 6'd4;
   localparam logic [5:0] OP_BNE  = 6'd5;
   localparam logic [5:0] OP_ADDI = 6'd8;
   localparam logic [5:0] OP_SLTI = 6'd10;
   localparam logic [5:0] OP_ANDI = 6'd12;
   localparam logic [5:0] OP_ORI  = 6'd13;
   localparam logic [5:0] OP_LUI  = 6'd15;
   localparam logic [5:0] OP_LW   = 6'd35;
   localparam logic [5:0] OP_SW   = 6'd43;

   // function field values (bits 5:0) for the register form
   localparam logic [5:0] FN_SLL = 6'd0;
   localparam logic [5:0] FN_SRL = 6'd6;
   localparam logic [5:0] FN_ADD = 6'd32;
   localparam logic [5:0] FN_SUB = 6'd34;
   localparam logic [5:0] FN_AND = 6'd36;
   localparam logic [5:0] FN_OR  = 6'd37;
   localparam logic [5:0] FN_SLT = 6'd42;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SHL, ALU_SHR, ALU_PASSB
   } alu_op_e;

   typedef enum logic [1:0] {
      IMM_SIGN, IMM_ZERO, IMM_UPPER
   } imm_kind_e;

   typedef enum logic [1:0] {
      NPC_SEQ, NPC_BEQ, NPC_BNE, NPC_JUMP
   } npc_sel_e;

   typedef struct packed {
      logic      wr_en;
      logic      dst_rd;
      logic      use_imm;
      imm_kind_e imm_kind;
      alu_op_e   alu_op;
      logic      mem_rd;
      logic      mem_wr;
      npc_sel_e  npc_sel;
   } ctrl_t;

endpackage

// File: rtl/sc_risc32_decode.sv
module sc_risc32_decode
   import sc_risc32_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl          = '0;
      ctrl.imm_kind = IMM_SIGN;
      ctrl.alu_op   = ALU_ADD;
      ctrl.npc_sel  = NPC_SEQ;
      unique case (opcode)
         OP_REG: begin
            ctrl.dst_rd = 1'b1;
            ctrl.wr_en  = 1'b1;
            unique case (funct)
               FN_ADD:  ctrl.alu_op = ALU_ADD;
               FN_SUB:  ctrl.alu_op = ALU_SUB;
               FN_AND:  ctrl.alu_op = ALU_AND;
               FN_OR:   ctrl.alu_op = ALU_OR;
               FN_SLT:  ctrl.alu_op = ALU_SLT;
               FN_SLL:  ctrl.alu_op = ALU_SHL;
               FN_SRL:  ctrl.alu_op = ALU_SHR;
               default: ctrl.wr_en  = 1'b0;
            endcase
         end
         OP_ADDI: begin
            ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_ADD;
         end
         OP_SLTI: begin
            ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT;
         end
         OP_ANDI: begin
            ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_AND;
            ctrl.imm_kind = IMM_ZERO;
         end
         OP_ORI: begin
            ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_OR;
            ctrl.imm_kind = IMM_ZERO;
         end
         OP_LUI: begin
            ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_PASSB;
            ctrl.imm_kind = IMM_UPPER;
         end
         OP_LW: begin
            ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1;
         end
         OP_SW: begin
            ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1;
         end
         OP_BEQ:  ctrl.npc_sel = NPC_BEQ;
         OP_BNE:  ctrl.npc_sel = NPC_BNE;
         OP_JMP:  ctrl.npc_sel = NPC_JUMP;
         default: ctrl.npc_sel = NPC_SEQ;
      endcase
   end

endmodule

// File: rtl/sc_risc32_regfile.sv
module sc_risc32_regfile #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ADDR_W-1:0] rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic [ADDR_W-1:0] rd_o_idx,
   output logic [DATA_W-1:0] rd_o_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (DATA_W < 8) begin : g_bad_width
      $error("regfile DATA_W too small");
   end

   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      if (g == 0) begin : g_hardwired
         assign cells[g] = '0;
      end else begin : g_stored
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (wr_en && (wr_idx == ADDR_W'(g)))
               q <= wr_data;
         end
         assign cells[g] = q;
      end
   end

   assign rd_a_data = cells[rd_a_idx];
   assign rd_b_data = cells[rd_b_idx];
   assign rd_o_data = cells[rd_o_idx];

endmodule

// File: rtl/sc_risc32_alu.sv
module sc_risc32_alu
   import sc_risc32_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  alu_op_e                     op,
   input  logic [DATA_W-1:0]           a,
   input  logic [DATA_W-1:0]           b,
   input  logic [$clog2(DATA_W)-1:0]   shamt,
   output logic [DATA_W-1:0]           y
);

   always_comb begin
      unique case (op)
         ALU_ADD:   y = a + b;
         ALU_SUB:   y = a - b;
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_SLT:   y = ($signed(a) < $signed(b)) ? DATA_W'(1) : '0;
         ALU_SHL:   y = b << shamt;
         ALU_SHR:   y = b >> shamt;
         ALU_PASSB: y = b;
         default:   y = '0;
      endcase
   end

endmodule

// File: rtl/sc_risc32_core.sv
module sc_risc32_core
   import sc_risc32_pkg::*;
#(
   parameter int unsigned IMEM_WORDS = 64,
   parameter int unsigned DMEM_WORDS = 64
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          imem_we,
   input  logic [$clog2(IMEM_WORDS)-1:0] imem_waddr,
   input  logic [31:0]                   imem_wdata,
   input  logic [4:0]                    dbg_reg_sel,
   output logic [31:0]                   dbg_reg_data,
   input  logic [$clog2(DMEM_WORDS)-1:0] dbg_mem_idx,
   output logic [31:0]                   dbg_mem_data,
   output logic [31:0]                   fetch_pc
);

   localparam int unsigned XLEN = 32;
   localparam int unsigned RA_W = 5;
   localparam int unsigned IA_W = $clog2(IMEM_WORDS);
   localparam int unsigned DA_W = $clog2(DMEM_WORDS);

   if (IMEM_WORDS < 2 || (IMEM_WORDS & (IMEM_WORDS - 1)) != 0 || IA_W > 28) begin : g_bad_imem
      $error("IMEM_WORDS must be a power of two between 2 and 2**28");
   end
   if (DMEM_WORDS < 2 || (DMEM_WORDS & (DMEM_WORDS - 1)) != 0 || DA_W > 28) begin : g_bad_dmem
      $error("DMEM_WORDS must be a power of two between 2 and 2**28");
   end

   // fetch
   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
   logic [XLEN-1:0] instr;
   logic [XLEN-1:0] imem [IMEM_WORDS];

   always_ff @(posedge clk) begin
      if (imem_we)
         imem[imem_waddr] <= imem_wdata;
   end

   assign instr = imem[pc_q[IA_W+1:2]];

   // fields
   logic [5:0]      opcode, funct;
   logic [RA_W-1:0] rs_idx, rt_idx, rd_idx, shamt;
   logic [15:0]     imm16;

   assign opcode = instr[31:26];
   assign rs_idx = instr[25:21];
   assign rt_idx = instr[20:16];
   assign rd_idx = instr[15:11];
   assign shamt  = instr[10:6];
   assign funct  = instr[5:0];
   assign imm16  = instr[15:0];

   ctrl_t ctrl;

   sc_risc32_decode u_decode (
      .opcode (opcode),
      .funct  (funct),
      .ctrl   (ctrl)
   );

   // operands
   logic [XLEN-1:0] rs_data, rt_data, imm_sx, imm_ext, alu_b, alu_y;
   logic [XLEN-1:0] load_data, wb_data;
   logic [RA_W-1:0] wb_idx;
   logic            wb_en;

   assign imm_sx = {{(XLEN-16){imm16[15]}}, imm16};

   always_comb begin
      unique case (ctrl.imm_kind)
         IMM_ZERO:  imm_ext = {{(XLEN-16){1'b0}}, imm16};
         IMM_UPPER: imm_ext = {imm16, {(XLEN-16){1'b0}}};
         default:   imm_ext = imm_sx;
      endcase
   end

   assign alu_b = ctrl.use_imm ? imm_ext : rt_data;

   sc_risc32_alu #(.DATA_W(XLEN)) u_alu (
      .op    (ctrl.alu_op),
      .a     (rs_data),
      .b     (alu_b),
      .shamt (shamt),
      .y     (alu_y)
   );

   // data memory: combinational read, write on the edge
   logic [XLEN-1:0] dmem [DMEM_WORDS];
   logic [DA_W-1:0] dm_idx;

   assign dm_idx    = alu_y[DA_W+1:2];
   assign load_data = dmem[dm_idx];

   always_ff @(posedge clk) begin
      if (!rst && ctrl.mem_wr)
         dmem[dm_idx] <= rt_data;
   end

   assign dbg_mem_data = dmem[dbg_mem_idx];

   // writeback
   assign wb_data = ctrl.mem_rd ? load_data : alu_y;
   assign wb_idx  = ctrl.dst_rd ? rd_idx : rt_idx;
   assign wb_en   = ctrl.wr_en && (wb_idx != '0);

   sc_risc32_regfile #(.DATA_W(XLEN), .ADDR_W(RA_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .rd_a_idx  (rs_idx),
      .rd_a_data (rs_data),
      .rd_b_idx  (rt_idx),
      .rd_b_data (rt_data),
      .rd_o_idx  (dbg_reg_sel),
      .rd_o_data (dbg_reg_data),
      .wr_en     (wb_en),
      .wr_idx    (wb_idx),
      .wr_data   (wb_data)
   );

   // next program counter
   assign pc_plus4   = pc_q + XLEN'(4);
   assign br_target  = pc_plus4 + (imm_sx << 2);
   assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

   always_comb begin
      unique case (ctrl.npc_sel)
         NPC_BEQ:  pc_next = (rs_data == rt_data) ? br_target : pc_plus4;
         NPC_BNE:  pc_next = (rs_data != rt_data) ? br_target : pc_plus4;
         NPC_JUMP: pc_next = jmp_target;
         default:  pc_next = pc_plus4;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_next;
   end

   assign fetch_pc = pc_q;

endmodule

// File: rtl/sc_risc32_chk.sv
module sc_risc32_chk (
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc,
   input logic [31:0] instr,
   input logic [31:0] rs_val,
   input logic [31:0] rt_val,
   input logic [4:0]  dbg_reg_sel,
   input logic [31:0] dbg_reg_data
);

   logic [5:0]  op;
   logic [31:0] seq_pc, br_pc, j_pc;
   logic        br_take, is_flow;

   assign op      = instr[31:26];
   assign seq_pc  = pc + 32'd4;
   assign br_pc   = seq_pc + ({{16{instr[15]}}, instr[15:0]} << 2);
   assign j_pc    = {seq_pc[31:28], instr[25:0], 2'b00};
   assign br_take = (op == 6'd4 && rs_val == rt_val) || (op == 6'd5 && rs_val != rt_val);
   assign is_flow = (op == 6'd2) || (op == 6'd4) || (op == 6'd5);

   // R1
   p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc == 32'd0);
   // R1
   p_reset_regs_r1: assert property (@(posedge clk) rst |=> dbg_reg_data == 32'd0);
   // R2
   p_zero_reg_r2: assert property (@(posedge clk) disable iff (rst)
      dbg_reg_sel == 5'd0 |-> dbg_reg_data == 32'd0);
   // R8
   p_branch_taken_r8: assert property (@(posedge clk) disable iff (rst)
      br_take |=> pc == $past(br_pc));
   // R8
   p_branch_fall_r8: assert property (@(posedge clk) disable iff (rst)
      ((op == 6'd4 || op == 6'd5) && !br_take) |=> pc == $past(seq_pc));
   // R9
   p_jump_r9: assert property (@(posedge clk) disable iff (rst)
      op == 6'd2 |=> pc == $past(j_pc));
   // R10
   p_sequential_r10: assert property (@(posedge clk) disable iff (rst)
      !is_flow |=> pc == $past(seq_pc));
   // R10
   p_aligned_r10: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00);

endmodule

bind sc_risc32_core sc_risc32_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .pc           (pc_q),
   .instr        (instr),
   .rs_val       (rs_data),
   .rt_val       (rt_data),
   .dbg_reg_sel  (dbg_reg_sel),
   .dbg_reg_data (dbg_reg_data)
);

// File: tb/test_sc_risc32_core.sv
module test_sc_risc32_core;

   localparam int IW  = 64;
   localparam int DW  = 64;
   localparam int IAW = 6;
   localparam int DAW = 6;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           imem_we = 1'b0;
   logic [IAW-1:0] imem_waddr = '0;
   logic [31:0]    imem_wdata = '0;
   logic [4:0]     dbg_reg_sel = '0;
   logic [31:0]    dbg_reg_data;
   logic [DAW-1:0] dbg_mem_idx = '0;
   logic [31:0]    dbg_mem_data;
   logic [31:0]    fetch_pc;

   always #2ns clk = ~clk;

   sc_risc32_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_sc_risc32_core (
      .clk          (clk),
      .rst          (rst),
      .imem_we      (imem_we),
      .imem_waddr   (imem_waddr),
      .imem_wdata   (imem_wdata),
      .dbg_reg_sel  (dbg_reg_sel),
      .dbg_reg_data (dbg_reg_data),
      .dbg_mem_idx  (dbg_mem_idx),
      .dbg_mem_data (dbg_mem_data),
      .fetch_pc     (fetch_pc)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [31:0] prog  [IW];
   logic [31:0] m_reg [32];
   logic [31:0] m_mem [DW];
   bit          m_valid [DW];
   logic [31:0] m_pc;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // encoders
   function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd, int sh);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
   endfunction
   function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
      return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
   endfunction
   function automatic logic [31:0] enc_j(int word_idx);
      return {6'd2, 26'(word_idx)};
   endfunction

   // instruction-level reference model
   task automatic model_step();
      logic [31:0] ins, a, b, se, ze, res, npc, addr;
      logic [5:0]  op, fn;
      int          rs, rt, rd, sh, dst;
      ins  = prog[m_pc[IAW+1:2]];
      op   = ins[31:26];
      fn   = ins[5:0];
      rs   = int'(ins[25:21]);
      rt   = int'(ins[20:16]);
      rd   = int'(ins[15:11]);
      sh   = int'(ins[10:6]);
      a    = m_reg[rs];
      b    = m_reg[rt];
      se   = {{16{ins[15]}}, ins[15:0]};
      ze   = {16'h0, ins[15:0]};
      addr = a + se;
      npc  = m_pc + 32'd4;
      res  = '0;
      dst  = -1;
      case (op)
         6'd0: begin
            dst = rd;
            case (fn)
               6'd32:   res = a + b;
               6'd34:   res = a - b;
               6'd36:   res = a & b;
               6'd37:   res = a | b;
               6'd42:   res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
               6'd0:    res = b << sh;
               6'd6:    res = b >> sh;
               default: dst = -1;
            endcase
         end
         6'd8:  begin res = a + se; dst = rt; end
         6'd10: begin res = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0; dst = rt; end
         6'd12: begin res = a & ze; dst = rt; end
         6'd13: begin res = a | ze; dst = rt; end
         6'd15: begin res = {ins[15:0], 16'h0}; dst = rt; end
         6'd35: begin res = m_mem[addr[DAW+1:2]]; dst = rt; end
         6'd43: begin m_mem[addr[DAW+1:2]] = b; m_valid[addr[DAW+1:2]] = 1'b1; end
         6'd4:  if (a == b) npc = m_pc + 32'd4 + (se << 2);
         6'd5:  if (a != b) npc = m_pc + 32'd4 + (se << 2);
         6'd2:  npc = {npc[31:28], ins[25:0], 2'b00};
         default: ;
      endcase
      if (dst > 0) m_reg[dst] = res;
      m_pc = npc;
   endtask

   task automatic read_reg(input int r, output logic [31:0] v);
      dbg_reg_sel = 5'(r);
      #100ps;
      v = dbg_reg_data;
   endtask

   task automatic read_mem(input int w, output logic [31:0] v);
      dbg_mem_idx = DAW'(w);
      #100ps;
      v = dbg_mem_data;
   endtask

   // load program words 0..n-1 under reset, then run for the given cycles
   task automatic run_prog(input int n_words, input int cycles);
      rst = 1'b1;
      for (int i = 0; i < n_words; i++) begin
         @(negedge clk);
         imem_we    = 1'b1;
         imem_waddr = IAW'(i);
         imem_wdata = prog[i];
      end
      @(negedge clk);
      imem_we = 1'b0;
      @(negedge clk);
      for (int r = 0; r < 32; r++) m_reg[r] = '0;
      m_pc = '0;
      rst  = 1'b0;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         model_step();
      end
   endtask

   task automatic compare_all(input string scen);
      logic [31:0] v;
      for (int r = 0; r < 32; r++) begin
         read_reg(r, v);
         chk($sformatf("R12 %s reg r%0d", scen, r), v, m_reg[r]);
      end
      chk($sformatf("R11 %s pc", scen), fetch_pc, m_pc);
      for (int w = 0; w < DW; w++) begin
         if (m_valid[w]) begin
            read_mem(w, v);
            chk($sformatf("R12 %s mem word %0d", scen, w), v, m_mem[w]);
         end
      end
   endtask

   task automatic t_reset(input string scen);
      logic [31:0] v;
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk({"R1 pc after reset ", scen}, fetch_pc, 32'd0);
      for (int r = 0; r < 32; r++) begin
         read_reg(r, v);
         chk($sformatf("R1 %s reg r%0d cleared", scen, r), v, 32'd0);
      end
   endtask

   task automatic t_example();
      logic [31:0] v;
      prog[0] = enc_i(15, 0, 5, 16'h1234);
      prog[1] = enc_i(13, 5, 5, 16'h5678);
      prog[2] = enc_i(8, 0, 15, -3);
      prog[3] = 32'h00AF8020;
      prog[4] = enc_i(8, 0, 0, 77);
      prog[5] = enc_r(32, 0, 16, 1, 0);
      prog[6] = enc_j(6);
      run_prog(7, 10);
      read_reg(16, v); chk("R3 fixed add word into r16", v, 32'h12345675);
      read_reg(0, v);  chk("R2 r0 after addi to r0", v, 32'd0);
      read_reg(1, v);  chk("R2 r0 read as source", v, 32'h12345675);
      chk("R11 example pc", fetch_pc, 32'd24);
      compare_all("example");
   endtask

   task automatic t_alu();
      logic [31:0] v;
      prog[0]  = enc_i(8, 0, 1, -20);
      prog[1]  = enc_i(8, 0, 2, 7);
      prog[2]  = enc_r(34, 1, 2, 3, 0);
      prog[3]  = enc_r(36, 1, 2, 4, 0);
      prog[4]  = enc_r(37, 1, 2, 5, 0);
      prog[5]  = enc_r(42, 1, 2, 6, 0);
      prog[6]  = enc_r(42, 2, 1, 7, 0);
      prog[7]  = enc_i(15, 0, 9, 16'hDF5A);
      prog[8]  = enc_i(13, 9, 9, 16'h48F5);
      prog[9]  = enc_r(0, 0, 9, 10, 8);
      prog[10] = enc_r(6, 0, 10, 11, 4);
      prog[11] = enc_r(6, 0, 9, 12, 31);
      prog[12] = enc_j(12);
      run_prog(13, 16);
      read_reg(3, v);  chk("R3 sub negative", v, 32'hFFFFFFE5);
      read_reg(6, v);  chk("R3 slt signed true", v, 32'd1);
      read_reg(7, v);  chk("R3 slt signed false", v, 32'd0);
      read_reg(10, v); chk("R4 shift left by 8", v, 32'h5A48F500);
      read_reg(11, v); chk("R4 shift right by 4", v, 32'h05A48F50);
      read_reg(12, v); chk("R4 shift right zero fill", v, 32'd1);
      compare_all("alu");
   endtask

   task automatic t_imm();
      logic [31:0] v;
      prog[0] = enc_i(8, 0, 1, -1);
      prog[1] = enc_i(10, 1, 2, -5);
      prog[2] = enc_i(10, 1, 3, 0);
      prog[3] = enc_i(12, 1, 4, 16'hFFFF);
      prog[4] = enc_i(13, 0, 5, 16'h8000);
      prog[5] = enc_i(15, 0, 6, 16'hAAAA);
      prog[6] = enc_i(13, 6, 6, 16'hAAAA);
      prog[7] = enc_i(8, 6, 7, 16'h7FFF);
      prog[8] = enc_j(8);
      run_prog(9, 12);
      read_reg(1, v); chk("R5 addi sign extends", v, 32'hFFFFFFFF);
      read_reg(2, v); chk("R5 slti -1<-5 false", v, 32'd0);
      read_reg(3, v); chk("R5 slti -1<0 true", v, 32'd1);
      read_reg(4, v); chk("R6 andi zero extends", v, 32'h0000FFFF);
      read_reg(5, v); chk("R6 ori zero extends", v, 32'h00008000);
      read_reg(6, v); chk("R6 lui plus ori constant", v, 32'hAAAAAAAA);
      compare_all("imm");
   endtask

   task automatic t_mem();
      logic [31:0] v;
      prog[0] = enc_i(8, 0, 2, 8);
      prog[1] = enc_i(8, 0, 5, 105);
      prog[2] = enc_i(43, 2, 5, 12);
      prog[3] = enc_i(8, 0, 3, 40);
      prog[4] = enc_i(43, 3, 3, -4);
      prog[5] = enc_i(35, 2, 6, 12);
      prog[6] = enc_i(35, 3, 7, -4);
      prog[7] = enc_i(43, 0, 6, 0);
      prog[8] = enc_i(35, 0, 0, 0);
      prog[9] = enc_j(9);
      run_prog(10, 14);
      read_mem(5, v); chk("R7 store array element word 5", v, 32'd105);
      read_mem(9, v); chk("R7 store negative offset word 9", v, 32'd40);
      read_mem(0, v); chk("R7 store at address 0", v, 32'd105);
      read_reg(6, v); chk("R7 load positive offset", v, 32'd105);
      read_reg(7, v); chk("R7 load negative offset", v, 32'd40);
      read_reg(0, v); chk("R2 load into r0 discarded", v, 32'd0);
      compare_all("mem");
   endtask

   task automatic t_branch(input int j_val);
      logic [31:0] v;
      prog[0]  = enc_i(8, 0, 3, 4);
      prog[1]  = enc_i(8, 0, 4, j_val);
      prog[2]  = enc_i(8, 0, 1, 10);
      prog[3]  = enc_i(8, 0, 2, 3);
      prog[4]  = enc_i(5, 3, 4, 2);
      prog[5]  = enc_r(32, 1, 2, 16, 0);
      prog[6]  = enc_j(8);
      prog[7]  = enc_r(34, 1, 2, 16, 0);
      prog[8]  = enc_i(8, 0, 5, 3);
      prog[9]  = enc_i(8, 6, 6, 2);
      prog[10] = enc_i(8, 5, 5, -1);
      prog[11] = enc_i(5, 5, 0, -3);
      prog[12] = enc_i(4, 3, 4, 1);
      prog[13] = enc_i(8, 0, 7, 99);
      prog[14] = enc_i(5, 3, 3, 1);
      prog[15] = enc_i(8, 0, 8, 5);
      prog[16] = enc_j(16);
      run_prog(17, 30);
      read_reg(16, v); chk($sformatf("R8 if-then-else result j=%0d", j_val), v, (j_val == 4) ? 32'd13 : 32'd7);
      read_reg(6, v);  chk("R8 backward loop count", v, 32'd6);
      read_reg(7, v);  chk("R8 beq skip", v, (j_val == 4) ? 32'd0 : 32'd99);
      read_reg(8, v);  chk("R8 bne fall through", v, 32'd5);
      chk("R9 jump to self pc", fetch_pc, 32'd64);
      compare_all($sformatf("branch%0d", j_val));
   endtask

   task automatic t_illegal();
      logic [31:0] v;
      prog[0] = enc_i(8, 0, 1, 5);
      prog[1] = enc_i(63, 1, 1, 0);
      prog[2] = enc_r(1, 1, 1, 2, 0);
      prog[3] = enc_i(9, 0, 3, 7);
      prog[4] = enc_i(40, 0, 1, 0);
      prog[5] = enc_i(8, 1, 4, 1);
      prog[6] = enc_j(6);
      run_prog(7, 10);
      read_reg(1, v); chk("R10 undefined opcode keeps rt", v, 32'd5);
      read_reg(2, v); chk("R10 undefined funct writes nothing", v, 32'd0);
      read_reg(3, v); chk("R10 unimplemented opcode writes nothing", v, 32'd0);
      read_mem(0, v); chk("R10 undefined store-like opcode", v, 32'd105);
      read_reg(4, v); chk("R10 execution continues", v, 32'd6);
      compare_all("illegal");
   endtask

   initial begin
      #400us;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int w = 0; w < DW; w++) begin
         m_valid[w] = 1'b0;
         m_mem[w]   = '0;
      end
      for (int i = 0; i < IW; i++) prog[i] = '0;
      t_reset("initial");
      t_example();
      t_alu();
      t_imm();
      t_mem();
      t_branch(4);
      t_branch(5);
      t_illegal();
      t_reset("after run");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule